// File: doc/BRIEF.md
# Dual-Mode Clock-Crossing Output FIFO

This block is an eight-entry first-in first-out buffer whose write port and read port run on unrelated clocks. Each entry carries a bundle of byte-wide lanes written together in one write-clock cycle. On the read side, a lane-mapping stage presents the head entry in one of two layouts. The nibble layout passes twelve 4-bit lanes straight through: the low half of every byte lane, plus the upper halves of lanes 5 and 6. The byte layout serialises every byte lane into two 4-bit read beats.

Occupancy is tracked with binary pointers that cross between the clock domains as Gray code through two-flop synchronisers. The write side drives full and almost-full from its own pointer and the synchronised read pointer. The read side drives empty and almost-empty the same way. The read port is show-ahead: while empty is low, `rd_data` already shows the current beat, and a cycle with `rd_en` high consumes it. The layout is chosen by `lane_mode` and is latched only while the read reset is high.

Top module: `dual_mode_out_fifo`

## Requirements
- R1: With no reads, the buffer accepts exactly 8 writes before `full` rises, and entries come out in the order they were written.
- R2: With `lane_mode` = 0 (nibble layout), for each lane n in 0..9, `rd_data[8n+3:8n]` equals `wr_data[8n+3:8n]` of the head entry.
- R3: In nibble layout, `rd_data[47:44]` and `rd_data[55:52]` carry `wr_data[47:44]` and `wr_data[55:52]` (upper halves of lanes 5 and 6). Every other upper half of `rd_data` reads 0, whatever the input upper halves hold.
- R4: With `lane_mode` = 1 (byte layout), each entry gives two read beats. The first beat shows `wr_data[8n+3:8n]` on `rd_data[8n+3:8n]`, and the second shows `wr_data[8n+7:8n+4]`. All upper halves of `rd_data` read 0, and the entry is not released (empty stays low) until the second beat is consumed.
- R5: `full` and `almost_full` change only with `wr_clk`. `almost_full` is high when the write side's view of occupancy is at least 8 − THRESH.
- R6: `empty` and `almost_empty` change only with `rd_clk`. `almost_empty` is high when the read side's view of occupancy is at most THRESH, and `empty` is high at zero.
- R7: A write attempted while `full` is high stores nothing and does not move the write pointer.
- R8: A read attempted while `empty` is high does not move the read pointer or the beat phase.
- R9: After both resets, `empty` and `almost_empty` are 1, and `full` and `almost_full` are 0.
- R10: THRESH is 1 or 2. Once an almost flag rises, at least THRESH further writes (or reads) still succeed, and full (or empty) is always preceded by its almost flag.
- R11: `lane_mode` is latched only during read reset. Changing it afterwards does not change the layout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-domain clock |
| wr_rst | input | 1 | Synchronous active-high write-domain reset |
| wr_en | input | 1 | Write request |
| wr_data | input | 80 | Ten byte lanes, lane n at [8n+7:8n] |
| full | output | 1 | No free entry (write domain) |
| almost_full | output | 1 | At most THRESH free entries (write domain) |
| rd_clk | input | 1 | Read-domain clock |
| rd_rst | input | 1 | Synchronous active-high read-domain reset |
| rd_en | input | 1 | Consume the current read beat |
| lane_mode | input | 1 | 0 nibble layout, 1 byte layout; latched during read reset |
| rd_data | output | 80 | Show-ahead lane view of the head entry |
| empty | output | 1 | No entry to read (read domain) |
| almost_empty | output | 1 | At most THRESH entries held (read domain) |

## Verification
The assertions assume that each side's reset is held for at least three of its own clock cycles. They also assume that the two resets overlap, so that neither domain starts out with a stale synchronised pointer from the other. The stimulus asserts both resets together for six cycles of each clock before releasing them. Inputs change only at falling edges. The bench reads `lane_mode` through the design only after a reset, and moves it outside reset solely to show that the layout is ignored there.

// File: rtl/ofifo_pkg.sv
package ofifo_pkg;

    typedef enum logic {
        LANE_NIB  = 1'b0,
        LANE_BYTE = 1'b1
    } lane_mode_e;

    typedef struct packed {
        logic [3:0] hi;
        logic [3:0] lo;
    } lane_t;

    // Presents one stored byte lane in the selected layout.
    function automatic lane_t lane_view(input lane_t d, input logic byte_mode,
                                        input logic phase, input logic extra);
        lane_t r;
        if (byte_mode) begin
            r.lo = phase ? d.hi : d.lo;
            r.hi = 4'h0;
        end else begin
            r.lo = d.lo;
            r.hi = extra ? d.hi : 4'h0;
        end
        return r;
    endfunction

endpackage

// File: rtl/ofifo_sync.sv
module ofifo_sync #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] gray_in,
    output logic [W-1:0] bin_out
);
    logic [W-1:0] stage1;
    logic [W-1:0] stage2;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1 <= '0;
            stage2 <= '0;
        end else begin
            stage1 <= gray_in;
            stage2 <= stage1;
        end
    end

    always_comb begin
        bin_out[W-1] = stage2[W-1];
        for (int i = W - 2; i >= 0; i--) begin
            bin_out[i] = bin_out[i+1] ^ stage2[i];
        end
    end
endmodule

// File: rtl/ofifo_wr_side.sv
module ofifo_wr_side #(
    parameter int DEPTH  = 8,
    parameter int THRESH = 1,
    localparam int AW    = $clog2(DEPTH),
    localparam int PW    = AW + 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [PW-1:0] rbin_s,
    output logic [PW-1:0] wgray,
    output logic [AW-1:0] waddr,
    output logic          wfire,
    output logic          full,
    output logic          almost_full
);
    logic [PW-1:0] wbin;
    logic [PW-1:0] wbin_nxt;
    logic [PW-1:0] level;

    assign level       = wbin - rbin_s;
    assign full        = (level == PW'(DEPTH));
    assign almost_full = (level >= PW'(DEPTH - THRESH));
    assign wfire       = wr_en && !full;
    assign wbin_nxt    = wbin + PW'(wfire);
    assign waddr       = wbin[AW-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            wbin  <= '0;
            wgray <= '0;
        end else begin
            wbin  <= wbin_nxt;
            wgray <= wbin_nxt ^ (wbin_nxt >> 1);
        end
    end

    a_r1_wr_level_bound: assert property (@(posedge clk) disable iff (rst)
        level <= PW'(DEPTH));
    a_r5_gray_one_step: assert property (@(posedge clk) disable iff (rst)
        $countones(wgray ^ $past(wgray)) <= 1);
    a_r10_full_after_almost: assert property (@(posedge clk) disable iff (rst)
        $rose(full) |-> $past(almost_full));
    a_r7_full_write_dropped: assert property (@(posedge clk) disable iff (rst)
        (wr_en && full) |=> $stable(waddr));
endmodule

// File: rtl/ofifo_rd_side.sv
module ofifo_rd_side #(
    parameter int DEPTH  = 8,
    parameter int THRESH = 1,
    localparam int AW    = $clog2(DEPTH),
    localparam int PW    = AW + 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          rd_en,
    input  logic          byte_mode,
    input  logic [PW-1:0] wbin_s,
    output logic [PW-1:0] rgray,
    output logic [AW-1:0] raddr,
    output logic          phase,
    output logic          empty,
    output logic          almost_empty
);
    logic [PW-1:0] rbin;
    logic [PW-1:0] rbin_nxt;
    logic [PW-1:0] level;
    logic          rfire;
    logic          advance;

    assign level        = wbin_s - rbin;
    assign empty        = (level == '0);
    assign almost_empty = (level <= PW'(THRESH));
    assign rfire        = rd_en && !empty;
    assign advance      = rfire && (!byte_mode || phase);
    assign rbin_nxt     = rbin + PW'(advance);
    assign raddr        = rbin[AW-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            rbin  <= '0;
            rgray <= '0;
            phase <= 1'b0;
        end else begin
            rbin  <= rbin_nxt;
            rgray <= rbin_nxt ^ (rbin_nxt >> 1);
            if (rfire && byte_mode) begin
                phase <= !phase;
            end
        end
    end

    a_r6_rd_level_bound: assert property (@(posedge clk) disable iff (rst)
        level <= PW'(DEPTH));
    a_r8_empty_no_half_entry: assert property (@(posedge clk) disable iff (rst)
        empty |-> !phase);
    a_r4_first_beat_holds: assert property (@(posedge clk) disable iff (rst)
        (rfire && byte_mode && !phase) |=> (phase && $stable(rgray)));
    a_r2_nibble_single_beat: assert property (@(posedge clk) disable iff (rst)
        !byte_mode |-> !phase);
    a_r10_empty_after_almost: assert property (@(posedge clk) disable iff (rst)
        $rose(empty) |-> $past(almost_empty));
endmodule

// File: rtl/ofifo_lane_map.sv
module ofifo_lane_map
    import ofifo_pkg::*;
#(
    parameter int LANES = 10,
    parameter int XA    = 5,
    parameter int XB    = 6,
    localparam int W    = LANES * 8
) (
    input  logic [W-1:0] head,
    input  logic         byte_mode,
    input  logic         phase,
    output logic [W-1:0] q
);
    for (genvar n = 0; n < LANES; n++) begin : g_lane
        localparam logic IS_EXTRA = (n == XA) || (n == XB);
        lane_t din;
        lane_t dout;
        assign din          = head[n*8 +: 8];
        assign dout         = lane_view(din, byte_mode, phase, IS_EXTRA);
        assign q[n*8 +: 8]  = dout;
    end
endmodule

// File: rtl/dual_mode_out_fifo.sv
module dual_mode_out_fifo
    import ofifo_pkg::*;
#(
    parameter int DEPTH  = 8,
    parameter int THRESH = 1,
    parameter int LANES  = 10,
    parameter int XA     = 5,
    parameter int XB     = 6,
    localparam int AW    = $clog2(DEPTH),
    localparam int PW    = AW + 1,
    localparam int W     = LANES * 8
) (
    input  logic         wr_clk,
    input  logic         wr_rst,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    output logic         full,
    output logic         almost_full,
    input  logic         rd_clk,
    input  logic         rd_rst,
    input  logic         rd_en,
    input  logic         lane_mode,
    output logic [W-1:0] rd_data,
    output logic         empty,
    output logic         almost_empty
);
    logic [W-1:0]  store [DEPTH];
    logic [PW-1:0] wgray, rgray, wbin_s, rbin_s;
    logic [AW-1:0] waddr, raddr;
    logic          wfire;
    logic          phase;
    lane_mode_e    mode_q;
    logic          byte_mode;

    always_ff @(posedge rd_clk) begin
        if (rd_rst) begin
            mode_q <= lane_mode_e'(lane_mode);
        end
    end
    assign byte_mode = (mode_q == LANE_BYTE);

    always_ff @(posedge wr_clk) begin
        if (wfire) begin
            store[waddr] <= wr_data;
        end
    end

    ofifo_wr_side #(.DEPTH(DEPTH), .THRESH(THRESH)) u_wr (
        .clk(wr_clk), .rst(wr_rst), .wr_en(wr_en), .rbin_s(rbin_s),
        .wgray(wgray), .waddr(waddr), .wfire(wfire),
        .full(full), .almost_full(almost_full)
    );

    ofifo_sync #(.W(PW)) u_r2w (
        .clk(wr_clk), .rst(wr_rst), .gray_in(rgray), .bin_out(rbin_s)
    );

    ofifo_sync #(.W(PW)) u_w2r (
        .clk(rd_clk), .rst(rd_rst), .gray_in(wgray), .bin_out(wbin_s)
    );

    ofifo_rd_side #(.DEPTH(DEPTH), .THRESH(THRESH)) u_rd (
        .clk(rd_clk), .rst(rd_rst), .rd_en(rd_en), .byte_mode(byte_mode),
        .wbin_s(wbin_s), .rgray(rgray), .raddr(raddr), .phase(phase),
        .empty(empty), .almost_empty(almost_empty)
    );

    ofifo_lane_map #(.LANES(LANES), .XA(XA), .XB(XB)) u_map (
        .head(store[raddr]), .byte_mode(byte_mode), .phase(phase), .q(rd_data)
    );

    a_r11_mode_frozen: assert property (@(posedge rd_clk) disable iff (rd_rst)
        $stable(mode_q));
endmodule

// File: tb/test_dual_mode_out_fifo.sv
`timescale 1ns/100ps
module test_dual_mode_out_fifo;
    localparam int DEPTH  = 8;
    localparam int THRESH = 1;
    localparam int LANES  = 10;
    localparam int W      = LANES * 8;

    logic         wr_clk = 0, rd_clk = 0;
    logic         wr_rst = 1, rd_rst = 1;
    logic         wr_en = 0, rd_en = 0, lane_mode = 0;
    logic [W-1:0] wr_data = '0;
    logic [W-1:0] rd_data;
    logic         full, almost_full, empty, almost_empty;

    int total = 0, bad = 0;
    logic [W-1:0] sb[$];

    always #2   wr_clk = ~wr_clk;
    always #3.5 rd_clk = ~rd_clk;

    dual_mode_out_fifo #(.DEPTH(DEPTH), .THRESH(THRESH)) i_dual_mode_out_fifo (
        .wr_clk(wr_clk), .wr_rst(wr_rst), .wr_en(wr_en), .wr_data(wr_data),
        .full(full), .almost_full(almost_full),
        .rd_clk(rd_clk), .rd_rst(rd_rst), .rd_en(rd_en), .lane_mode(lane_mode),
        .rd_data(rd_data), .empty(empty), .almost_empty(almost_empty)
    );

    function automatic logic [W-1:0] mk(input int k);
        logic [W-1:0] r;
        for (int n = 0; n < LANES; n++) r[n*8 +: 8] = 8'((k * 37 + n * 11 + 5 + (n << 4)) & 255) | 8'h10;
        return r;
    endfunction

    function automatic logic [W-1:0] exp_q(input logic [W-1:0] w, input bit bm, input bit ph);
        logic [W-1:0] r;
        for (int n = 0; n < LANES; n++) begin
            logic [7:0] b;
            b = w[n*8 +: 8];
            r[n*8 +: 4]     = bm ? (ph ? b[7:4] : b[3:0]) : b[3:0];
            r[n*8 + 4 +: 4] = (!bm && (n == 5 || n == 6)) ? b[7:4] : 4'h0;
        end
        return r;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic chk1(input logic act, input logic exp, input string req);
        chk(act === exp, req, W'(act), W'(exp));
    endtask

    task automatic report();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    task automatic reset_all(input logic mode);
        wr_rst = 1; rd_rst = 1; lane_mode = mode; wr_en = 0; rd_en = 0;
        sb.delete();
        fork
            begin repeat (6) @(negedge wr_clk); wr_rst = 0; @(negedge wr_clk); end
            begin repeat (6) @(negedge rd_clk); rd_rst = 0; @(negedge rd_clk); end
        join
    endtask

    task automatic settle();
        repeat (6) @(negedge rd_clk);
        repeat (6) @(negedge wr_clk);
    endtask

    task automatic push(input logic [W-1:0] d);
        @(negedge wr_clk);
        while (full) @(negedge wr_clk);
        wr_en = 1; wr_data = d;
        sb.push_back(d);
        @(negedge wr_clk);
        wr_en = 0;
    endtask

    task automatic pop(input bit bm, input string req);
        logic [W-1:0] head;
        @(negedge rd_clk);
        while (empty) @(negedge rd_clk);
        head = sb.pop_front();
        chk(rd_data === exp_q(head, bm, 0), req, rd_data, exp_q(head, bm, 0));
        rd_en = 1;
        @(negedge rd_clk);
        if (bm) begin
            chk1(empty, 1'b0, "R4 entry held after first beat");
            chk(rd_data === exp_q(head, 1, 1), "R4 second beat", rd_data, exp_q(head, 1, 1));
            @(negedge rd_clk);
        end
        rd_en = 0;
    endtask

    task automatic stream(input bit bm, input int base);
        fork
            for (int k = 0; k < 40; k++) begin
                push(mk(base + k));
                if (k % 3 == 0) repeat (2) @(negedge wr_clk);
            end
            for (int k = 0; k < 40; k++) begin
                pop(bm, bm ? "R4 streaming order" : "R1 R2 R3 streaming order");
                if (k % 4 == 1) repeat (3) @(negedge rd_clk);
            end
        join
    endtask

    initial begin
        repeat (150000) @(posedge wr_clk);
        total++; bad++;
        $display("FAIL watchdog expired actual=hung expected=done");
        report();
    end

    initial begin
        // Reset state, nibble layout
        reset_all(0);
        chk1(empty, 1'b1, "R9 empty after reset");
        chk1(almost_empty, 1'b1, "R9 almost_empty after reset");
        chk1(full, 1'b0, "R9 full after reset");
        chk1(almost_full, 1'b0, "R9 almost_full after reset");

        // Fill without reads: almost_full and full counts (R5, R10, R1)
        for (int k = 0; k < DEPTH; k++) begin
            push(mk(k));
            chk1(almost_full, (k + 1 >= DEPTH - THRESH), "R5 R10 almost_full level");
            chk1(full, (k + 1 == DEPTH), "R1 full after depth writes");
        end

        // Writes while full must be dropped (R7)
        @(negedge wr_clk);
        wr_en = 1; wr_data = {W{1'b1}};
        repeat (3) @(negedge wr_clk);
        wr_en = 0;
        chk1(full, 1'b1, "R7 still full");
        settle();
        chk1(empty, 1'b0, "R6 not empty when filled");
        chk1(almost_empty, 1'b0, "R6 almost_empty low when filled");

        for (int k = 0; k < DEPTH; k++) begin
            pop(0, "R1 R2 R3 nibble layout and order");
            chk1(almost_empty, (DEPTH - k - 1 <= THRESH), "R6 R10 almost_empty level");
            chk1(empty, (k == DEPTH - 1), "R6 empty after last read");
        end
        settle();
        chk1(empty, 1'b1, "R7 dropped write left no entry");
        chk1(full, 1'b0, "R5 full cleared after drain");

        // Reads while empty must be ignored (R8)
        @(negedge rd_clk);
        rd_en = 1;
        repeat (3) @(negedge rd_clk);
        rd_en = 0;
        push(mk(100));
        settle();
        chk1(empty, 1'b0, "R8 entry visible after ignored reads");
        pop(0, "R8 data intact after ignored reads");
        chk1(empty, 1'b1, "R8 empty again");

        // Mode input moved outside reset has no effect (R11)
        lane_mode = 1;
        push(mk(200));
        settle();
        pop(0, "R11 layout unchanged outside reset");
        chk1(empty, 1'b1, "R11 single beat consumed entry");

        // Byte layout
        reset_all(1);
        chk1(empty, 1'b1, "R9 empty after reset byte");
        chk1(full, 1'b0, "R9 full after reset byte");
        for (int k = 0; k < DEPTH; k++) push(mk(300 + k));
        chk1(full, 1'b1, "R1 full in byte layout");
        settle();
        for (int k = 0; k < DEPTH; k++) begin
            pop(1, "R4 first beat low half");
            chk1(empty, (k == DEPTH - 1), "R4 empty only after second beat");
        end

        stream(1, 400);
        settle();
        chk1(empty, 1'b1, "R4 empty after byte stream");

        reset_all(0);
        stream(0, 600);
        settle();
        chk1(empty, 1'b1, "R1 empty after nibble stream");
        chk1(almost_full, 1'b0, "R5 almost_full low after stream");

        report();
    end
endmodule